// File: doc/BRIEF.md
# Over-Temperature Shutdown Latch

This block turns a one-bit over-limit flag from an on-die temperature comparator into a sticky core shutdown. The comparator trips far above normal operating temperature, near 135 °C. The flag is asynchronous to the core clock, so it first passes through a flop synchronizer. Once the synchronized flag is seen, the block halts the core and pulls a registered, active-low trip output low. Both stay that way until reset, even after the die cools.

The block adds no hysteresis. The comparator's single threshold decides both entry and release. Reset is a level sampled on the core clock. While it is held, the latch follows the synchronized flag. If the die is still over the limit, the trip output stays low and the core stays halted through reset and after it. If the flag has cleared, the latch empties and execution resumes once reset is released.

The control is a three-state machine:
- `ST_RESET`: in reset, cool.
- `ST_RUN`: executing.
- `ST_TRIP`: latched shutdown.

Its transitions are:
- `reset_cool`: any state to `ST_RESET` while reset is held and the flag is clear.
- `reset_hot`: any state to `ST_TRIP` while reset is held and the flag is set.
- `release`: `ST_RESET` to `ST_RUN` on the first cycle out of reset with the flag clear.
- `release_hot`: `ST_RESET` to `ST_TRIP` on the first cycle out of reset with the flag set.
- `trip`: `ST_RUN` to `ST_TRIP` when the flag is set.
- `hold`: `ST_RUN` and `ST_TRIP` stay put otherwise.

Top module: `thermtrip_latch`

## Requirements
- R1: With reset held low and the flag clear, after at most SYNC_STAGES+2 clock edges `core_halt_o` is 0 and `trip_n_o` is 1. Both stay so after reset is released while the flag remains clear.
- R2: When the flag rises outside reset, `trip_n_o` goes to 0 and `core_halt_o` goes to 1 on the (SYNC_STAGES+1)-th rising edge after the flag is first sampled high. They do not change before that edge. With the default of 2 stages, that is the third edge.
- R3: Once `trip_n_o` is 0 outside reset, it stays 0 and `core_halt_o` stays 1 for as long as reset stays high, whatever the flag does.
- R4: Holding reset low while the flag is clear empties the latch. `trip_n_o` returns to 1 and `core_halt_o` to 0, and after release the block runs untripped.
- R5: If the flag is set while reset is held, the latch is set. `trip_n_o` stays 0 through reset and after release, and `core_halt_o` stays 1.
- R6: There is no minimum duration or margin. A flag that is high at a single rising edge trips the latch.
- R7: While reset is held, `core_halt_o` is the OR of the latched trip and the synchronized flag. A flag rising in reset raises `core_halt_o` one edge before `trip_n_o` falls.
- R8: Outside reset, with the flag held clear, neither output ever asserts.
- R9: `core_halt_o` is 1 whenever `trip_n_o` is 0. Outside reset, `core_halt_o` is 1 only while `trip_n_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low reset, sampled as a level on `clk_i` |
| over_temp_i | input | 1 | Asynchronous over-limit flag from the temperature comparator, 1 = too hot |
| core_halt_o | output | 1 | 1 = core execution halted |
| trip_n_o | output | 1 | Registered trip indication, 0 = thermal trip latched |

## Verification
A latch stuck in `ST_RUN` after a trip shows at the ports as `trip_n_o` rising again within one edge of the flag clearing. A latch that a cool reset fails to empty keeps `trip_n_o` low after release. A wrong synchronizer depth moves the trip edge by one or more cycles relative to the (SYNC_STAGES+1)-th edge, so the checks sample exactly at that edge and at the one before it. A broken halt path shows while reset is held, as `core_halt_o` failing to lead `trip_n_o` by one edge.

// File: rtl/thermtrip_pkg.sv
package thermtrip_pkg;

    // Default synchronizer depth for the asynchronous over-limit flag
    localparam int unsigned DEF_SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        ST_RESET = 2'b00,
        ST_RUN   = 2'b01,
        ST_TRIP  = 2'b10
    } thermtrip_state_e;

endpackage

// File: rtl/thermtrip_sync.sv
// Multi-flop synchronizer for the comparator flag. The stages carry no reset
// so that the flag keeps flowing while the core is held in reset.
module thermtrip_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic async_i,
    output logic sync_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] stage_q;

    always_ff @(posedge clk_i) begin
        stage_q[0] <= async_i;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk_i) begin
            stage_q[g] <= stage_q[g-1];
        end
    end

    assign sync_o = stage_q[LAST];
endmodule

// File: rtl/thermtrip_fsm.sv
// Shutdown state machine: reset follows the flag, run trips on it,
// trip holds until reset.
module thermtrip_fsm
    import thermtrip_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             hot_i,
    output thermtrip_state_e state_o,
    output thermtrip_state_e next_o
);
    thermtrip_state_e state_q;
    thermtrip_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (!rst_ni) begin
            // reset_hot / reset_cool
            state_d = hot_i ? ST_TRIP : ST_RESET;
        end else begin
            unique case (state_q)
                ST_RESET: state_d = hot_i ? ST_TRIP : ST_RUN;  // release_hot / release
                ST_RUN:   state_d = hot_i ? ST_TRIP : ST_RUN;  // trip / hold
                ST_TRIP:  state_d = ST_TRIP;                   // hold
                default:  state_d = ST_TRIP;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        state_q <= state_d;
    end

    assign state_o = state_q;
    assign next_o  = state_d;
endmodule

// File: rtl/thermtrip_outreg.sv
// Output stage: a dedicated flop for the trip pin, and the halt combination.
module thermtrip_outreg
    import thermtrip_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             hot_i,
    input  thermtrip_state_e state_i,
    input  thermtrip_state_e next_i,
    output logic             core_halt_o,
    output logic             trip_n_o
);
    logic trip_n_q;

    always_ff @(posedge clk_i) begin
        trip_n_q <= (next_i != ST_TRIP);
    end

    always_comb begin
        core_halt_o = (state_i == ST_TRIP) || (!rst_ni && hot_i);
        trip_n_o    = trip_n_q;
    end
endmodule

// File: rtl/thermtrip_latch.sv
module thermtrip_latch
    import thermtrip_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic over_temp_i,
    output logic core_halt_o,
    output logic trip_n_o
);
    logic             hot_sync;
    thermtrip_state_e state;
    thermtrip_state_e state_next;

    thermtrip_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .async_i (over_temp_i),
        .sync_o  (hot_sync)
    );

    thermtrip_fsm u_fsm (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .hot_i   (hot_sync),
        .state_o (state),
        .next_o  (state_next)
    );

    thermtrip_outreg u_out (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .hot_i       (hot_sync),
        .state_i     (state),
        .next_i      (state_next),
        .core_halt_o (core_halt_o),
        .trip_n_o    (trip_n_o)
    );
endmodule

// File: rtl/thermtrip_checker.sv
module thermtrip_checker #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic clk_i,
    input logic rst_ni,
    input logic over_temp_i,
    input logic core_halt_o,
    input logic trip_n_o
);
    localparam int unsigned LAT = SYNC_STAGES + 1;
    localparam int unsigned CW  = $clog2(LAT + 1);

    // Record of the flag over the last LAT edges, and how many edges are recorded
    logic [LAT-1:0] flag_hist = '0;
    logic [CW-1:0]  filled    = '0;

    always_ff @(posedge clk_i) begin
        flag_hist <= {flag_hist[LAT-2:0], over_temp_i};
        if (filled != CW'(LAT)) filled <= filled + 1'b1;
    end

    // R2: a flag sampled LAT edges ago must have tripped the latch by now
    assert_trip_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (filled == CW'(LAT) && flag_hist[LAT-1]) |-> !trip_n_o);

    // R3: outside reset, a latched trip never releases
    assert_trip_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !trip_n_o |=> !trip_n_o);

    // R9: a latched trip always halts the core
    assert_halt_on_trip_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !trip_n_o |-> core_halt_o);

    // R9: outside reset, halt appears only together with the trip
    assert_halt_only_trip_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trip_n_o |-> !core_halt_o);
endmodule

bind thermtrip_latch thermtrip_checker #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .over_temp_i (over_temp_i),
    .core_halt_o (core_halt_o),
    .trip_n_o    (trip_n_o)
);

// File: tb/thermtrip_latch_tb_top.sv
module thermtrip_latch_tb_top;
    localparam int NV = 20;

    // Row fields: [11] rst_n, [10] flag, [9:6] edges, [5] exp halt, [4] exp trip_n, [3:0] req
    localparam logic [11:0] VEC [NV] = '{
        {1'b0, 1'b0, 4'd6, 1'b0, 1'b1, 4'd1},  // R1 reset state, cool
        {1'b1, 1'b0, 4'd4, 1'b0, 1'b1, 4'd1},  // R1 release, cool
        {1'b1, 1'b1, 4'd2, 1'b0, 1'b1, 4'd2},  // R2 not yet tripped after 2 edges
        {1'b1, 1'b1, 4'd1, 1'b1, 1'b0, 4'd2},  // R2 tripped on 3rd edge
        {1'b1, 1'b0, 4'd6, 1'b1, 1'b0, 4'd3},  // R3 stays latched after cooling
        {1'b0, 1'b0, 4'd5, 1'b0, 1'b1, 4'd4},  // R4 cool reset empties latch
        {1'b1, 1'b0, 4'd4, 1'b0, 1'b1, 4'd4},  // R4 runs after release
        {1'b1, 1'b1, 4'd1, 1'b0, 1'b1, 4'd6},  // R6 one-edge pulse
        {1'b1, 1'b0, 4'd2, 1'b1, 1'b0, 4'd6},  // R6 pulse has tripped
        {1'b1, 1'b1, 4'd4, 1'b1, 1'b0, 4'd3},  // R3 still hot, latched
        {1'b0, 1'b1, 4'd5, 1'b1, 1'b0, 4'd5},  // R5 hot reset keeps trip
        {1'b1, 1'b1, 4'd3, 1'b1, 1'b0, 4'd5},  // R5 after release, still tripped
        {1'b1, 1'b0, 4'd4, 1'b1, 1'b0, 4'd3},  // R3 cooled, no reset
        {1'b0, 1'b0, 4'd4, 1'b0, 1'b1, 4'd4},  // R4 cool reset
        {1'b0, 1'b1, 4'd2, 1'b1, 1'b1, 4'd7},  // R7 halt leads trip in reset
        {1'b0, 1'b1, 4'd1, 1'b1, 1'b0, 4'd7},  // R7 trip follows one edge later
        {1'b1, 1'b1, 4'd2, 1'b1, 1'b0, 4'd5},  // R5 release while hot
        {1'b1, 1'b0, 4'd3, 1'b1, 1'b0, 4'd3},  // R3 cools outside reset
        {1'b0, 1'b0, 4'd4, 1'b0, 1'b1, 4'd4},  // R4 cool reset
        {1'b1, 1'b0, 4'd3, 1'b0, 1'b1, 4'd8}   // R8 quiet run
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hot = 1'b0;
    logic halt;
    logic trip_n;
    int   n_checks = 0;
    int   n_fail = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    thermtrip_latch dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .over_temp_i (hot),
        .core_halt_o (halt),
        .trip_n_o    (trip_n)
    );

    task automatic check(input int req, input logic exp_halt, input logic exp_trip_n);
        n_checks++;
        if (halt !== exp_halt || trip_n !== exp_trip_n) begin
            n_fail++;
            $display("FAIL R%0d: halt=%b trip_n=%b expected halt=%b trip_n=%b",
                     req, halt, trip_n, exp_halt, exp_trip_n);
        end
    endtask

    task automatic step(input logic r, input logic h, input int edges);
        rst_n = r;
        hot   = h;
        repeat (edges) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][11], VEC[i][10], int'(VEC[i][9:6]));
            check(int'(VEC[i][3:0]), VEC[i][5], VEC[i][4]);
        end

        // R8 / R9: long cool run, checked every cycle
        for (int c = 0; c < 40; c++) begin
            step(1'b1, 1'b0, 1);
            check(8, 1'b0, 1'b1);  // R8
        end

        // R2 across release: flag rises on the same edge reset is released
        step(1'b0, 1'b0, 4);
        check(1, 1'b0, 1'b1);      // R1
        step(1'b1, 1'b1, 2);
        check(2, 1'b0, 1'b1);      // R2 not before third edge
        step(1'b1, 1'b1, 1);
        check(2, 1'b1, 1'b0);      // R2 third edge
        step(1'b1, 1'b0, 10);
        check(9, 1'b1, 1'b0);      // R9 halt tracks trip

        // R6: pulse toggling, latch must not release
        for (int c = 0; c < 6; c++) begin
            step(1'b1, c[0], 1);
            check(3, 1'b1, 1'b0);  // R3
        end

        // R4: final cool reset and release
        step(1'b0, 1'b0, 5);
        check(4, 1'b0, 1'b1);
        step(1'b1, 1'b0, 3);
        check(4, 1'b0, 1'b1);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual=hung expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule